// File: doc/BRIEF.md
# Codec Control Word Double Buffer

This block sits between a host register port and a serial audio frame generator. It holds two codec control words, each with its own enable bit and frame start position, which the serializer places into every outgoing frame. The host writes a pair of words in one strobe. The pair lands in a staging buffer, and the busy output rises. At the next frame start the pending pair moves into the shadow registers that feed the serializer, and busy falls.

Shadow values stay in place until a newer pair is committed. The serializer therefore repeats the last committed pair in every frame for as long as the host stays silent. Software that needs a distinct pair in each of several successive frames polls busy and writes the next pair only when busy reads 0. No interrupt is raised.

The enable bits and start positions have their own write strobe. They are staged as well, and they reach the shadow side only at a frame start, so nothing seen by the serializer changes part-way through a frame. The host inputs carry no back-pressure: every strobe is taken in the cycle it is asserted.

Top module: `ccr_double_buf`

## Requirements
- R1: While reset is asserted and after it is released, busy is 0, both shadow words are 0, both shadow enables are 0 (disabled) and both shadow positions are 0.
- R2: A cycle with pair_we high captures pair_w0 and pair_w1 into the staging buffer, and busy reads 1 from the next cycle on.
- R3: A frame_start cycle in which busy is 1 copies both staged words into sh_w0 and sh_w1, visible in the next cycle. In that same next cycle busy reads 0, unless a pair write also arrived in the frame_start cycle.
- R4: The shadow words change only in the cycle after a frame_start that finds busy at 1. At every other time, including any number of frame starts with no new pair, the shadow words hold their last committed values.
- R5: A pair write made while busy is 1 replaces the staged pair, and busy stays 1. Only the last pair written before a frame start is committed.
- R6: When pair_we and frame_start fall in the same cycle, the commit takes the pair staged before that cycle, the new pair is staged, and busy stays 1 until the following frame start.
- R7: A cycle with cfg_we high stages cfg_en, cfg_pos0 and cfg_pos1. Bit 0 of cfg_en enables word 0 and bit 1 enables word 1, with 1 meaning enabled. On every frame_start the staged values are copied to sh_en, sh_pos0 and sh_pos1, visible in the next cycle. They never change at any other time, and cfg_we has no effect on busy.
- R8: When cfg_we and frame_start fall in the same cycle, the shadow takes the previously staged configuration, and the newly written values appear only after the following frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pair_we | input | 1 | Write strobe for the control word pair |
| pair_w0 | input | WORD_W | Control word 0 to stage |
| pair_w1 | input | WORD_W | Control word 1 to stage |
| cfg_we | input | 1 | Write strobe for enables and positions |
| cfg_en | input | 2 | Enable bits to stage, bit i for word i |
| cfg_pos0 | input | POS_W | First frame bit position of word 0 |
| cfg_pos1 | input | POS_W | First frame bit position of word 1 |
| frame_start | input | 1 | One-cycle pulse marking the first cycle of a frame |
| busy | output | 1 | 1 while a written pair waits for commit |
| sh_w0 | output | WORD_W | Committed control word 0 |
| sh_w1 | output | WORD_W | Committed control word 1 |
| sh_en | output | 2 | Committed enable bits |
| sh_pos0 | output | POS_W | Committed start position of word 0 |
| sh_pos1 | output | POS_W | Committed start position of word 1 |

## Verification
Every result is due exactly one rising edge after its cause: busy after a pair write or a committing frame start, the shadow words after a committing frame start, and the shadow configuration after any frame start. The bench drives each stimulus on the falling edge. A behavioural model applies that stimulus at the rising edge that follows, and every output is compared with the model on the next falling edge, so each result is checked in the cycle it is due and in every cycle it must hold. Same-cycle collisions of write and frame start are driven on purpose, to show that the commit sees the pre-edge staging contents.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  // Occupancy of the staging buffer for the control word pair
  typedef enum logic {
    HOLD_EMPTY = 1'b0,
    HOLD_FULL  = 1'b1
  } hold_e;

  // Width of a bit index into a frame of the given length
  function automatic int unsigned pos_width(input int unsigned frame_len);
    return (frame_len <= 2) ? 1 : $clog2(frame_len);
  endfunction

endpackage

// File: rtl/ccr_load_reg.sv
module ccr_load_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/ccr_pair_buf.sv
module ccr_pair_buf
  import ccr_pkg::*;
#(
  parameter int unsigned PAIR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAIR_W-1:0] wr_data,
  input  logic              frame_start,
  output logic [PAIR_W-1:0] stage_data,
  output logic              pending,
  output logic              commit
);

  hold_e state_q, state_d;

  // A frame start only commits when a pair is waiting
  assign commit  = frame_start && (state_q == HOLD_FULL);
  assign pending = (state_q == HOLD_FULL);

  always_comb begin
    state_d = state_q;
    if (wr_en)       state_d = HOLD_FULL;   // new or overwriting write
    else if (commit) state_d = HOLD_EMPTY;  // pair handed to shadow
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HOLD_EMPTY;
    else        state_q <= state_d;
  end

  ccr_load_reg #(.W(PAIR_W)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_en),
    .d     (wr_data),
    .q     (stage_data)
  );

endmodule

// File: rtl/ccr_double_buf.sv
module ccr_double_buf
  import ccr_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned FRAME_LEN = 64,
  parameter int unsigned POS_W     = pos_width(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_we,
  input  logic [WORD_W-1:0] pair_w0,
  input  logic [WORD_W-1:0] pair_w1,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_en,
  input  logic [POS_W-1:0]  cfg_pos0,
  input  logic [POS_W-1:0]  cfg_pos1,
  input  logic              frame_start,
  output logic              busy,
  output logic [WORD_W-1:0] sh_w0,
  output logic [WORD_W-1:0] sh_w1,
  output logic [1:0]        sh_en,
  output logic [POS_W-1:0]  sh_pos0,
  output logic [POS_W-1:0]  sh_pos1
);

  localparam int unsigned NSLOT  = 2;
  localparam int unsigned PAIR_W = NSLOT * WORD_W;
  localparam int unsigned SLOT_W = 1 + POS_W;        // enable + position
  localparam int unsigned CFG_W  = NSLOT * SLOT_W;

  logic [PAIR_W-1:0] pair_in, stage_pair, sh_pair;
  logic [CFG_W-1:0]  cfg_in, cfg_staged, cfg_shadow;
  logic              commit;

  assign pair_in = {pair_w1, pair_w0};
  // slot i occupies bits [i*SLOT_W +: SLOT_W] as {position, enable}
  assign cfg_in  = {cfg_pos1, cfg_en[1], cfg_pos0, cfg_en[0]};

  ccr_pair_buf #(.PAIR_W(PAIR_W)) u_pair (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (pair_we),
    .wr_data     (pair_in),
    .frame_start (frame_start),
    .stage_data  (stage_pair),
    .pending     (busy),
    .commit      (commit)
  );

  ccr_load_reg #(.W(CFG_W)) u_cfg_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_we),
    .d     (cfg_in),
    .q     (cfg_staged)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    ccr_load_reg #(.W(WORD_W)) u_word_sh (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (commit),
      .d     (stage_pair[s*WORD_W +: WORD_W]),
      .q     (sh_pair[s*WORD_W +: WORD_W])
    );
    ccr_load_reg #(.W(SLOT_W)) u_cfg_sh (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (frame_start),
      .d     (cfg_staged[s*SLOT_W +: SLOT_W]),
      .q     (cfg_shadow[s*SLOT_W +: SLOT_W])
    );
    assign sh_en[s] = cfg_shadow[s*SLOT_W];
  end

  assign sh_w0   = sh_pair[0 +: WORD_W];
  assign sh_w1   = sh_pair[WORD_W +: WORD_W];
  assign sh_pos0 = cfg_shadow[1 +: POS_W];
  assign sh_pos1 = cfg_shadow[SLOT_W+1 +: POS_W];

endmodule

// File: rtl/ccr_checker.sv
module ccr_checker #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned POS_W  = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pair_we,
  input logic                    cfg_we,
  input logic                    frame_start,
  input logic                    busy,
  input logic [WORD_W-1:0]       sh_w0,
  input logic [WORD_W-1:0]       sh_w1,
  input logic [1:0]              sh_en,
  input logic [POS_W-1:0]        sh_pos0,
  input logic [POS_W-1:0]        sh_pos1,
  input logic [2*WORD_W-1:0]     stage_pair,
  input logic [2*(1+POS_W)-1:0]  cfg_staged
);

  p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_we |=> busy);

  p_busy_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pair_we) |=> !busy);

  p_commit_words_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && busy) |=> ({sh_w1, sh_w0} == $past(stage_pair)));

  p_busy_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && busy && !pair_we) |=> !busy);

  p_words_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && busy) |=> ($stable(sh_w0) && $stable(sh_w1)));

  p_busy_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_start) |=> busy);

  p_busy_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_we && frame_start) |=> busy);

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(sh_en) && $stable(sh_pos0) && $stable(sh_pos1)));

  p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> ({sh_pos1, sh_en[1], sh_pos0, sh_en[0]} == $past(cfg_staged)));

endmodule

bind ccr_double_buf ccr_checker #(.WORD_W(WORD_W), .POS_W(POS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pair_we     (pair_we),
  .cfg_we      (cfg_we),
  .frame_start (frame_start),
  .busy        (busy),
  .sh_w0       (sh_w0),
  .sh_w1       (sh_w1),
  .sh_en       (sh_en),
  .sh_pos0     (sh_pos0),
  .sh_pos1     (sh_pos1),
  .stage_pair  (stage_pair),
  .cfg_staged  (cfg_staged)
);

// File: tb/sim_ccr_double_buf.sv
`timescale 1ns/1ps
module sim_ccr_double_buf;

  localparam int WW = 16;
  localparam int PW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pair_we = 1'b0, cfg_we = 1'b0, frame_start = 1'b0;
  logic [WW-1:0] pair_w0 = '0, pair_w1 = '0;
  logic [1:0]    cfg_en = '0;
  logic [PW-1:0] cfg_pos0 = '0, cfg_pos1 = '0;
  logic          busy;
  logic [WW-1:0] sh_w0, sh_w1;
  logic [1:0]    sh_en;
  logic [PW-1:0] sh_pos0, sh_pos1;

  always #2 clk = ~clk;   // 250 MHz

  ccr_double_buf #(.WORD_W(WW), .FRAME_LEN(64)) u0 (
    .clk(clk), .rst_n(rst_n), .pair_we(pair_we), .pair_w0(pair_w0),
    .pair_w1(pair_w1), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_pos0(cfg_pos0), .cfg_pos1(cfg_pos1), .frame_start(frame_start),
    .busy(busy), .sh_w0(sh_w0), .sh_w1(sh_w1), .sh_en(sh_en),
    .sh_pos0(sh_pos0), .sh_pos1(sh_pos1)
  );

  // Behavioural reference: one pending pair, one staged configuration
  int            m_busy = 0;
  int            m_stage0 = 0, m_stage1 = 0, m_sh0 = 0, m_sh1 = 0;
  int            m_cen = 0, m_cp0 = 0, m_cp1 = 0;
  int            m_shen = 0, m_shp0 = 0, m_shp1 = 0;
  int            n_cmp = 0, n_bad = 0, cycles = 0;
  string         cur_req = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_stage0 = 0; m_stage1 = 0; m_sh0 = 0; m_sh1 = 0;
      m_cen = 0; m_cp0 = 0; m_cp1 = 0; m_shen = 0; m_shp0 = 0; m_shp1 = 0;
    end else begin
      if (frame_start) begin
        if (m_busy != 0) begin
          m_sh0 = m_stage0; m_sh1 = m_stage1; m_busy = 0;
        end
        m_shen = m_cen; m_shp0 = m_cp0; m_shp1 = m_cp1;
      end
      if (pair_we) begin
        m_stage0 = int'(pair_w0); m_stage1 = int'(pair_w1); m_busy = 1;
      end
      if (cfg_we) begin
        m_cen = int'(cfg_en); m_cp0 = int'(cfg_pos0); m_cp1 = int'(cfg_pos1);
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare every output on every falling edge
  always @(negedge clk) begin
    cmp("busy",    int'(busy),    m_busy);
    cmp("sh_w0",   int'(sh_w0),   m_sh0);
    cmp("sh_w1",   int'(sh_w1),   m_sh1);
    cmp("sh_en",   int'(sh_en),   m_shen);
    cmp("sh_pos0", int'(sh_pos0), m_shp0);
    cmp("sh_pos1", int'(sh_pos1), m_shp1);
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish_run();
    end
  end

  task automatic cyc(bit we, int w0, int w1, bit cwe, int en, int p0, int p1, bit fs);
    @(negedge clk);
    pair_we = we; pair_w0 = WW'(w0); pair_w1 = WW'(w1);
    cfg_we = cwe; cfg_en = 2'(en); cfg_pos0 = PW'(p0); cfg_pos1 = PW'(p1);
    frame_start = fs;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    // R1: reset values held during and after reset
    cur_req = "R1";
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);  // frame with nothing staged: all stay 0
    idle(2);

    // R2: pair write raises busy, shadow untouched
    cur_req = "R2";
    cyc(1, 16'h1234, 16'hABCD, 0, 0, 0, 0, 0);
    idle(4);

    // R3: frame start commits, busy clears
    cur_req = "R3";
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(2);

    // R4: repeated frames keep the committed pair
    cur_req = "R4";
    for (int f = 0; f < 5; f++) begin
      cyc(0, 0, 0, 0, 0, 0, 0, 1);
      idle(3);
    end

    // R5: overwrite while busy, only the last pair commits
    cur_req = "R5";
    cyc(1, 16'h1111, 16'h2222, 0, 0, 0, 0, 0);
    idle(1);
    cyc(1, 16'h3333, 16'h4444, 0, 0, 0, 0, 0);
    idle(2);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(2);

    // R6: write collides with frame start
    cur_req = "R6";
    cyc(1, 16'h5555, 16'h6666, 0, 0, 0, 0, 0);
    cyc(1, 16'h7777, 16'h8888, 0, 0, 0, 0, 1);
    idle(3);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(2);
    cyc(1, 16'h9999, 16'hAAAA, 0, 0, 0, 0, 1); // collide with nothing pending
    idle(2);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(2);

    // R7: configuration staged, applied at frame start, busy untouched
    cur_req = "R7";
    cyc(0, 0, 0, 1, 2'b01, 17, 40, 0);
    idle(3);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(2);
    cyc(0, 0, 0, 1, 2'b10, 63, 0, 0);
    idle(2);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(2);

    // R8: configuration write collides with frame start
    cur_req = "R8";
    cyc(0, 0, 0, 1, 2'b11, 5, 50, 1);
    idle(2);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(2);

    // R4, R5, R6, R7: mixed traffic
    cur_req = "R4";
    for (int k = 0; k < 600; k++) begin
      cyc(($urandom % 5) == 0, int'($urandom % 65536), int'($urandom % 65536),
          ($urandom % 7) == 0, int'($urandom % 4), int'($urandom % 64),
          int'($urandom % 64), ($urandom % 6) == 0);
    end
    idle(3);

    // R1: reset mid-run returns to reset values
    cur_req = "R1";
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    finish_run();
  end

endmodule